// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns a decoded addressing mode and the operand bytes of an 8-bit processor instruction into the operand the execute stage needs. The result is one of three things. It can be an immediate value. It can be a sign-extended branch displacement. It can be a 16-bit effective address in a 64 KB space. For the three pointer-based modes, the block fetches a two-byte pointer through its own byte-wide read port. It reads the low byte first and then the byte at the next location. It then assembles the target from the two bytes.

The block also reports how many operand bytes the mode consumes, and the matching program-counter step (that count plus one for the opcode). The front end uses these to advance the program counter. One command is handled at a time. A command is taken on a valid/ready handshake and its result is offered on a second valid/ready handshake. The result stays on the outputs until the consumer takes it. The memory request follows the same rule: once raised, the request and its address stay unchanged until the memory accepts them. Each accepted request is answered by exactly one response pulse at any later cycle.

Top module: `ea_gen`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no command is in progress, so it is low from the accepting edge until the result has been handed over.
- R2: Modes that need no memory access (every mode except 9, 10, 11 and 12) raise `res_valid` at the edge that accepts the command. They issue no memory request.
- R3: Mode codes 0 (implied) and 1 (accumulator) give result kind 0 with data 0. Mode 2 (immediate) gives kind 1 with data equal to the low operand byte, zero-extended.
- R4: Mode codes 3 (page-zero direct), 4 (page-zero plus X) and 5 (page-zero plus Y) give kind 2. The address is the low operand byte plus the index, taken modulo 256, so the high address byte is always 0x00.
- R5: Mode codes 6 (absolute), 7 (absolute plus X) and 8 (absolute plus Y) give kind 2. The address is {high byte, low byte} plus the zero-extended index, taken modulo 65536.
- R6: Mode 13 (relative) gives kind 3 with the low operand byte sign-extended to 16 bits.
- R7: Mode 9 (indirect) uses {high byte, low byte} as the pointer. Every pointer mode issues exactly two reads: the first at the pointer and the second at the pointer plus one, taken modulo 65536. The result has kind 2 and is the second byte read shifted up by eight, ORed with the first byte read. `res_valid` rises at the edge that captures the second response.
- R8: Mode 12 (page-zero indirect) uses the pointer {0x00, low byte} and adds no index to the fetched address.
- R9: Mode 10 (pre-indexed) uses the pointer {0x00, (low byte + X) mod 256}. The second read still uses the 16-bit increment of that pointer.
- R10: Mode 11 (post-indexed) uses the pointer {0x00, low byte}. It adds Y to the fetched address, taken modulo 65536.
- R11: `res_nbytes` is 0 for modes 0 and 1, 2 for modes 6, 7, 8 and 9, and 1 for all other modes. `res_pc_step` equals `res_nbytes` plus one.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays raised and `mem_req_addr` does not change.
- R13: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_kind`, `res_data`, `res_nbytes` and `res_pc_step` hold their values. The result is released at the edge where both signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_mode | input | 4 | Addressing mode code |
| cmd_op_lo | input | DW | First operand byte |
| cmd_op_hi | input | DW | Second operand byte |
| cmd_idx_x | input | DW | X index register value |
| cmd_idx_y | input | DW | Y index register value |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 2*DW | Read address |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying read data |
| mem_rsp_data | input | DW | Read data |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Consumer takes the result |
| res_kind | output | 2 | 0 none, 1 value, 2 address, 3 offset |
| res_data | output | 2*DW | Value, address or sign-extended offset |
| res_nbytes | output | 2 | Operand bytes used by the mode |
| res_pc_step | output | 2 | Program-counter advance (operand bytes plus one) |

## Verification
For the direct modes the result is due at the same edge that accepts the command. The bench therefore samples `res_valid` at the first falling edge after that handshake and requires it to be high there. For the pointer modes with a memory that never stalls, the result is due four edges after acceptance: request low, capture low, request high, capture high. The bench counts falling edges from acceptance, requires the fifth to be the first that shows `res_valid`, and on stalled runs only requires the result to arrive within a bound. The bench also records which addresses each run reads and in what order, compares them with the pointer it works out for itself, and checks that a stalled request or an unconsumed result stays unchanged from one falling edge to the next.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_IMPL  = 4'd0,
    AM_ACC   = 4'd1,
    AM_IMM   = 4'd2,
    AM_ZP    = 4'd3,
    AM_ZPX   = 4'd4,
    AM_ZPY   = 4'd5,
    AM_ABS   = 4'd6,
    AM_ABSX  = 4'd7,
    AM_ABSY  = 4'd8,
    AM_IND   = 4'd9,
    AM_PREX  = 4'd10,
    AM_POSTY = 4'd11,
    AM_ZPIND = 4'd12,
    AM_REL   = 4'd13
  } am_e;

  typedef enum logic [1:0] {
    RK_NONE   = 2'd0,
    RK_VALUE  = 2'd1,
    RK_ADDR   = 2'd2,
    RK_OFFSET = 2'd3
  } rk_e;

  typedef enum logic [1:0] {
    T_IDLE = 2'd0,
    T_WALK = 2'd1,
    T_OUT  = 2'd2
  } top_st_e;

  typedef enum logic [2:0] {
    W_IDLE    = 3'd0,
    W_REQ_LO  = 3'd1,
    W_WAIT_LO = 3'd2,
    W_REQ_HI  = 3'd3,
    W_WAIT_HI = 3'd4
  } walk_st_e;

endpackage

// File: rtl/ea_mode_class.sv
module ea_mode_class
  import ea_pkg::*;
(
  input  logic [3:0] mode,
  output logic [1:0] nbytes,
  output logic       walk,
  output logic       post_y,
  output logic [1:0] kind
);

  am_e m;
  assign m = am_e'(mode);

  always_comb begin
    nbytes = 2'd1;
    walk   = 1'b0;
    post_y = 1'b0;
    kind   = RK_ADDR;
    case (m)
      AM_IMPL, AM_ACC: begin
        nbytes = 2'd0;
        kind   = RK_NONE;
      end
      AM_IMM:  kind = RK_VALUE;
      AM_REL:  kind = RK_OFFSET;
      AM_ABS, AM_ABSX, AM_ABSY: nbytes = 2'd2;
      AM_IND: begin
        nbytes = 2'd2;
        walk   = 1'b1;
      end
      AM_PREX, AM_ZPIND: walk = 1'b1;
      AM_POSTY: begin
        walk   = 1'b1;
        post_y = 1'b1;
      end
      AM_ZP, AM_ZPX, AM_ZPY: kind = RK_ADDR;
      default: begin
        nbytes = 2'd0;
        kind   = RK_NONE;
      end
    endcase
  end

endmodule

// File: rtl/ea_direct_calc.sv
module ea_direct_calc
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [3:0]    mode,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  output logic [AW-1:0] direct_data,
  output logic [AW-1:0] ptr
);

  am_e m;
  assign m = am_e'(mode);

  logic [DW-1:0] page_x;
  logic [DW-1:0] page_y;
  logic [AW-1:0] full_op;
  logic [AW-1:0] sext_lo;

  // page-zero sums drop their carry so the high byte stays clear
  assign page_x  = op_lo + idx_x;
  assign page_y  = op_lo + idx_y;
  assign full_op = {op_hi, op_lo};

  generate
    if (DW > 1) begin : g_sext
      assign sext_lo = {{DW{op_lo[DW-1]}}, op_lo};
    end else begin : g_sext1
      assign sext_lo = {{DW{op_lo[0]}}, op_lo};
    end
  endgenerate

  always_comb begin
    direct_data = '0;
    case (m)
      AM_IMM, AM_ZP: direct_data = {{DW{1'b0}}, op_lo};
      AM_ZPX:        direct_data = {{DW{1'b0}}, page_x};
      AM_ZPY:        direct_data = {{DW{1'b0}}, page_y};
      AM_ABS:        direct_data = full_op;
      AM_ABSX:       direct_data = full_op + AW'(idx_x);
      AM_ABSY:       direct_data = full_op + AW'(idx_y);
      AM_REL:        direct_data = sext_lo;
      default:       direct_data = '0;
    endcase
  end

  always_comb begin
    ptr = '0;
    case (m)
      AM_IND:             ptr = full_op;
      AM_PREX:            ptr = {{DW{1'b0}}, page_x};
      AM_POSTY, AM_ZPIND: ptr = {{DW{1'b0}}, op_lo};
      default:            ptr = '0;
    endcase
  end

endmodule

// File: rtl/ea_ptr_walker.sv
module ea_ptr_walker
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  input  logic [AW-1:0] start_off,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          done,
  output logic [AW-1:0] eff_addr
);

  walk_st_e      st;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] off_q;
  logic [DW-1:0] lo_q;

  assign mem_req_valid = (st == W_REQ_LO) || (st == W_REQ_HI);
  assign mem_req_addr  = (st == W_REQ_HI) ? ptr_q + AW'(1) : ptr_q;
  assign done          = (st == W_WAIT_HI) && mem_rsp_valid;
  assign eff_addr      = {mem_rsp_data, lo_q} + off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= W_IDLE;
      ptr_q <= '0;
      off_q <= '0;
      lo_q  <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          ptr_q <= start_ptr;
          off_q <= start_off;
          st    <= W_REQ_LO;
        end
        W_REQ_LO:  if (mem_req_ready) st <= W_WAIT_LO;
        W_WAIT_LO: if (mem_rsp_valid) begin
          lo_q <= mem_rsp_data;
          st   <= W_REQ_HI;
        end
        W_REQ_HI:  if (mem_req_ready) st <= W_WAIT_HI;
        W_WAIT_HI: if (mem_rsp_valid) st <= W_IDLE;
        default:   st <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [3:0]    cmd_mode,
  input  logic [DW-1:0] cmd_op_lo,
  input  logic [DW-1:0] cmd_op_hi,
  input  logic [DW-1:0] cmd_idx_x,
  input  logic [DW-1:0] cmd_idx_y,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [1:0]    res_kind,
  output logic [AW-1:0] res_data,
  output logic [1:0]    res_nbytes,
  output logic [1:0]    res_pc_step
);

  top_st_e       st;
  logic [1:0]    cls_nb;
  logic          cls_walk;
  logic          cls_post_y;
  logic [1:0]    cls_kind;
  logic [AW-1:0] dir_data;
  logic [AW-1:0] dir_ptr;
  logic          accept;
  logic          walk_start;
  logic          walk_done;
  logic [AW-1:0] walk_addr;
  logic [AW-1:0] walk_off;
  logic [1:0]    kind_q;
  logic [AW-1:0] data_q;
  logic [1:0]    nb_q;
  logic [1:0]    step_q;

  ea_mode_class u_class (
    .mode   (cmd_mode),
    .nbytes (cls_nb),
    .walk   (cls_walk),
    .post_y (cls_post_y),
    .kind   (cls_kind)
  );

  ea_direct_calc #(.DW(DW)) u_direct (
    .mode        (cmd_mode),
    .op_lo       (cmd_op_lo),
    .op_hi       (cmd_op_hi),
    .idx_x       (cmd_idx_x),
    .idx_y       (cmd_idx_y),
    .direct_data (dir_data),
    .ptr         (dir_ptr)
  );

  assign cmd_ready  = (st == T_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign walk_start = accept && cls_walk;
  assign walk_off   = cls_post_y ? AW'(cmd_idx_y) : '0;

  ea_ptr_walker #(.DW(DW)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (walk_start),
    .start_ptr     (dir_ptr),
    .start_off     (walk_off),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (walk_done),
    .eff_addr      (walk_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      kind_q <= RK_NONE;
      data_q <= '0;
      nb_q   <= '0;
      step_q <= '0;
    end else begin
      case (st)
        T_IDLE: if (accept) begin
          kind_q <= cls_kind;
          nb_q   <= cls_nb;
          step_q <= cls_nb + 2'd1;
          if (cls_walk) begin
            st <= T_WALK;
          end else begin
            data_q <= dir_data;
            st     <= T_OUT;
          end
        end
        T_WALK: if (walk_done) begin
          data_q <= walk_addr;
          st     <= T_OUT;
        end
        T_OUT:   if (res_ready) st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end

  assign res_valid   = (st == T_OUT);
  assign res_kind    = kind_q;
  assign res_data    = data_q;
  assign res_nbytes  = nb_q;
  assign res_pc_step = step_q;

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [3:0]    cmd_mode,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          res_valid,
  input logic          res_ready,
  input logic [1:0]    res_kind,
  input logic [AW-1:0] res_data,
  input logic [1:0]    res_nbytes
);

  logic [3:0]    mode_q;
  logic [1:0]    nreq_q;
  logic [AW-1:0] first_q;
  logic          cmd_hs;
  logic          direct_cmd;

  assign cmd_hs     = cmd_valid && cmd_ready;
  assign direct_cmd = !(cmd_mode inside {AM_IND, AM_PREX, AM_POSTY, AM_ZPIND});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      nreq_q  <= '0;
      first_q <= '0;
    end else begin
      if (cmd_hs) begin
        mode_q <= cmd_mode;
        nreq_q <= '0;
      end else if (mem_req_valid && mem_req_ready) begin
        if (nreq_q == 2'd0) first_q <= mem_req_addr;
        nreq_q <= nreq_q + 2'd1;
      end
    end
  end

  // R1: no new command while a request or a result is outstanding
  a_r1_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || mem_req_valid) |-> !cmd_ready);

  // R2: direct modes produce their result at the accepting edge
  a_r2_direct_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hs && direct_cmd) |=> (res_valid && !mem_req_valid));

  // R4: page-zero direct results keep a zero high byte
  a_r4_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (mode_q inside {AM_ZP, AM_ZPX, AM_ZPY})) |-> (res_data[AW-1:DW] == '0));

  // R6: offsets are one-byte operands sign-extended
  a_r6_offset_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == RK_OFFSET) |->
      (res_nbytes == 2'd1 && (res_data[AW-1:DW] == {DW{res_data[DW-1]}})));

  // R7: the second pointer read is at the first plus one
  a_r7_second_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && nreq_q == 2'd1) |-> (mem_req_addr == first_q + AW'(1)));

  // R11: modes without an operand report zero bytes
  a_r11_none_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == RK_NONE) |-> (res_nbytes == 2'd0));

  // R12: a stalled read request holds
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R13: an unconsumed result holds
  a_r13_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_data) && $stable(res_kind) && $stable(res_nbytes)));

endmodule

bind ea_gen ea_gen_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_mode      (cmd_mode),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_kind      (res_kind),
  .res_data      (res_data),
  .res_nbytes    (res_nbytes)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [3:0]    cmd_mode = '0;
  logic [DW-1:0] cmd_op_lo = '0;
  logic [DW-1:0] cmd_op_hi = '0;
  logic [DW-1:0] cmd_idx_x = '0;
  logic [DW-1:0] cmd_idx_y = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [1:0]    res_kind;
  logic [AW-1:0] res_data;
  logic [1:0]    res_nbytes;
  logic [1:0]    res_pc_step;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit bp_on = 0;
  int cyc = 0;
  bit pending = 0;
  int pend_addr = 0;
  int rd_cnt = 0;
  int rd_a0 = 0;
  int rd_a1 = 0;
  bit stalled = 0;
  int stall_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode),
    .cmd_op_lo(cmd_op_lo), .cmd_op_hi(cmd_op_hi),
    .cmd_idx_x(cmd_idx_x), .cmd_idx_y(cmd_idx_y),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_kind(res_kind),
    .res_data(res_data), .res_nbytes(res_nbytes), .res_pc_step(res_pc_step)
  );

  function automatic int mem_byte(input int a);
    return ((a & 255) ^ (((a >> 8) & 255) * 37) ^ 8'hA5) & 255;
  endfunction

  function automatic string tag_of(input int m);
    if (m <= 2) return "R3";
    if (m <= 5) return "R4";
    if (m <= 8) return "R5";
    if (m == 9) return "R7";
    if (m == 10) return "R9";
    if (m == 11) return "R10";
    if (m == 12) return "R8";
    return "R6";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one response pulse the cycle after acceptance
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (pending) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = DW'(mem_byte(pend_addr));
      pending = 0;
    end
    if (stalled) chk("R12 held request", {mem_req_valid, 16'(mem_req_addr)}, {1'b1, 16'(stall_addr)});
    mem_req_ready = bp_on ? cyc[0] : 1'b1;
    stalled = mem_req_valid && !mem_req_ready;
    stall_addr = int'(mem_req_addr);
    if (mem_req_valid && mem_req_ready) begin
      pend_addr = int'(mem_req_addr);
      pending = 1;
      if (rd_cnt == 0) rd_a0 = pend_addr;
      if (rd_cnt == 1) rd_a1 = pend_addr;
      rd_cnt++;
    end
  end

  task automatic run_vec(input int m, input int lo, input int hi, input int x, input int y,
                         input bit hold_res);
    int kind, data, nb, ptr, k;
    bit walk;
    string t;
    t = tag_of(m);
    walk = (m >= 9 && m <= 12);
    nb = (m <= 1) ? 0 : ((m >= 6 && m <= 9) ? 2 : 1);
    kind = (m <= 1) ? 0 : (m == 2) ? 1 : (m == 13) ? 3 : 2;
    ptr = 0;
    case (m)
      2, 3:  data = lo;
      4:     data = (lo + x) & 255;
      5:     data = (lo + y) & 255;
      6:     data = (hi << 8) | lo;
      7:     data = (((hi << 8) | lo) + x) & 65535;
      8:     data = (((hi << 8) | lo) + y) & 65535;
      13:    data = (lo >= 128) ? (lo | 16'hFF00) : lo;
      default: data = 0;
    endcase
    if (walk) begin
      ptr = (m == 9) ? ((hi << 8) | lo) : (m == 10) ? ((lo + x) & 255) : lo;
      data = ((mem_byte((ptr + 1) & 65535) << 8) | mem_byte(ptr));
      if (m == 11) data = (data + y) & 65535;
    end
    rd_cnt = 0;
    cmd_mode = 4'(m); cmd_op_lo = 8'(lo); cmd_op_hi = 8'(hi);
    cmd_idx_x = 8'(x); cmd_idx_y = 8'(y);
    cmd_valid = 1'b1;
    chk("R1 ready when idle", int'(cmd_ready), 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 1;
    chk("R1 busy after accept", int'(cmd_ready), 0);
    while (!res_valid && k < 40) begin
      @(negedge clk);
      k++;
    end
    if (!walk) chk("R2 direct latency", k, 1);
    else if (!bp_on) chk("R7 pointer latency", k, 5);
    chk({t, " data"}, int'(res_data), data);
    chk({t, " kind"}, int'(res_kind), kind);
    chk("R11 operand bytes", int'(res_nbytes), nb);
    chk("R11 pc step", int'(res_pc_step), nb + 1);
    chk({walk ? t : "R2", " read count"}, rd_cnt, walk ? 2 : 0);
    if (walk) begin
      chk({t, " first read"}, rd_a0, ptr);
      chk("R7 second read", rd_a1, (ptr + 1) & 65535);
    end
    if (hold_res) begin
      repeat (2) begin
        @(negedge clk);
        chk("R13 result held", {int'(res_valid), int'(res_data)}, {1, data});
      end
    end
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    chk("R13 released", int'(res_valid), 0);
    chk("R1 ready again", int'(cmd_ready), 1);
  endtask

  initial begin
    int los[5] = '{0, 1, 8'h7F, 8'h80, 8'hFF};
    int his[3] = '{0, 8'h12, 8'hFF};
    int xs[3]  = '{0, 1, 8'h80};
    int ys[3]  = '{0, 8'hFF, 8'h7F};
    int vi;
    vi = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(cmd_ready), 1);
    chk("R13 reset no result", int'(res_valid), 0);
    chk("R7 reset no request", int'(mem_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 14; m++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 3; b++)
          for (int c = 0; c < 3; c++) begin
            bp_on = vi[0];
            run_vec(m, los[a], his[b], xs[c], ys[c], (vi % 7) == 3);
            vi++;
          end
    bp_on = 0;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule